// File: doc/BRIEF.md
# Genlock Subcarrier Serial Transmitter

This block sends the colour subcarrier frequency control value out on one pin, once per scan line, one bit per serial clock. A slave decoder listens on that pin and steers its own colour phase loop to match. A frame begins a fixed number of clocks after a line-start pulse. It carries an active-low start bit and then the upper 22 bits of the 23-bit control word, most significant bit first. Seven clocks after the last data bit comes a phase-reset slot.

The host asks for a phase reset with a one-cycle pulse on `phase_req`. The request is held until the next line start, and the frame that follows drives the reset slot low. In that same cycle a one-cycle strobe tells the local subcarrier oscillator to clear its phase. The control word is copied into a shadow register at line start, so host updates during a frame do not disturb it. A disable input holds the pin high while the pin is given over to another function. Frame timing and the strobe carry on as normal while the pin is disabled.

Top module: `genlock_ser_tx`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), `ser_out` is 1, `phase_zero` is 0, and no phase-reset request is pending.
- R2: Outside a frame, `ser_out` is 1 and `phase_zero` is 0.
- R3: Slot k of a frame (k = 0..LEAD+29) appears on the outputs in the cycle after the (k+1)-th rising edge following the edge that samples `line_start` high. Slots 0..LEAD-1 are 1, and slot LEAD is the start bit, 0.
- R4: Slots LEAD+1..LEAD+22 carry `freq_word` bits 22 down to 1 in that order. Bit 0 is never sent.
- R5: The word is sampled at the edge that sees `line_start`. Later changes on `freq_word` do not change the frame in progress.
- R6: Slot LEAD+29, seven clocks after the last data slot, is 0 on a frame that carries a phase reset and 1 otherwise. Slots LEAD+23..LEAD+28 are 1.
- R7: A `phase_req` pulse is delivered on the frame started by the next `line_start`. A pulse at the same edge as `line_start` counts for that frame. Each request is delivered on exactly one frame.
- R8: `phase_zero` is 1 for exactly one cycle, in the reset-slot cycle of a frame that carries a reset, and is 0 at all other times.
- R9: A `line_start` during a frame restarts the frame at slot 0 with a newly captured word. A reset that the aborted frame had not yet sent is carried into the new frame.
- R10: While `pin_disable` is 1, `ser_out` is 1 from the next cycle on. Frame timing, request delivery and `phase_zero` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each scan line |
| freq_word | input | 23 | Subcarrier frequency control value |
| phase_req | input | 1 | One-cycle host request for a phase reset |
| pin_disable | input | 1 | Holds the serial pin high while it serves another function |
| ser_out | output | 1 | Serial genlock output, idles high |
| phase_zero | output | 1 | Clears the local subcarrier phase, coincident with the reset bit |

## Verification
The bench runs walking-one and walking-zero words through every data slot. A design that reversed the bit order, sent bit 0, or slipped the data by one clock would mismatch on a known slot. It changes the word in the middle of a frame, which catches a design that samples the live input instead of the shadow. It places requests mid-frame and on the same edge as the line start, and checks that the reset lands on the right frame and only there. It also restarts frames in the middle, both armed and unarmed, and runs frames with the pin disabled. These cases catch a design that drops or repeats a reset, or that lets the disable input alter the strobe.

// File: rtl/genlock_pkg.sv
// Package: shared slot classification for the genlock serial transmitter.
// Assumes a frame layout of idle lead-in, start bit, data, gap, phase slot.
package genlock_pkg;

    typedef enum logic [2:0] {
        SLOT_LEAD  = 3'd0,
        SLOT_START = 3'd1,
        SLOT_DATA  = 3'd2,
        SLOT_GAP   = 3'd3,
        SLOT_PHASE = 3'd4
    } slot_kind_e;

    // Classify a slot index given the frame geometry.
    function automatic slot_kind_e classify(input int k, input int lead,
                                            input int sent_w, input int gap);
        if (k < lead)                    return SLOT_LEAD;
        else if (k == lead)              return SLOT_START;
        else if (k <= lead + sent_w)     return SLOT_DATA;
        else if (k == lead + sent_w + gap) return SLOT_PHASE;
        else                             return SLOT_GAP;
    endfunction

endpackage

// File: rtl/genlock_frame_timer.sv
// Frame timer: starts a slot count at every line-start pulse and runs it
// through FRAME_LEN slots, then goes idle.
// Assumes line_start is a single-cycle pulse; a pulse while busy restarts.
module genlock_frame_timer #(
    parameter int FRAME_LEN = 34,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    output logic             busy,
    output logic [CNT_W-1:0] slot
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);

    // Slot counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (line_start) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (busy) begin
            if (slot == LAST_SLOT) busy <= 1'b0;
            else                   slot <= slot + 1'b1;
        end
    end

    // R3: a line start always opens a frame at slot 0.
    assert_frame_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (busy && slot == '0));

    // R2: a frame closes after its last slot unless restarted.
    assert_frame_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot == LAST_SLOT && !line_start) |=> !busy);

endmodule

// File: rtl/genlock_word_hold.sv
// Word hold: captures the transmitted bits of the control word at line
// start and tracks the host phase-reset request across scan lines.
// Assumes phase_req is a one-cycle pulse per host write.
module genlock_word_hold #(
    parameter int WORD_W   = 23,
    parameter int SENT_W   = WORD_W - 1,
    parameter int CNT_W    = 6,
    parameter int RST_SLOT = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              phase_req,
    input  logic              busy,
    input  logic [CNT_W-1:0]  slot,
    output logic [SENT_W-1:0] shadow,
    output logic              armed,
    output logic              pending
);
    localparam logic [CNT_W-1:0] PHASE_SLOT = CNT_W'(RST_SLOT);

    logic carry_over;

    // An armed frame cut off before its phase slot hands the reset onward.
    assign carry_over = armed && busy && (slot != PHASE_SLOT);

    // Shadow copy of the upper word bits, taken once per line.
    always_ff @(posedge clk) begin
        if (!rst_n)          shadow <= '0;
        else if (line_start) shadow <= freq_word[WORD_W-1:WORD_W-SENT_W];
    end

    // Request tracking: pending until the next line start, then armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            armed   <= 1'b0;
        end else if (line_start) begin
            pending <= 1'b0;
            armed   <= pending || phase_req || carry_over;
        end else begin
            pending <= pending || phase_req;
        end
    end

    // R7: a request outside a line start is held.
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req && !line_start) |=> pending);

    // R7: a line start consumes whatever was pending.
    assert_req_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !pending);

    // R5: the shadow word does not move during a frame.
    assert_shadow_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_start) |=> $stable(shadow));

endmodule

// File: rtl/genlock_bit_emit.sv
// Bit emitter: maps the current slot to the serial level and registers it,
// together with the phase-zero strobe for the reset slot.
// Assumes slot is meaningful only while busy is high.
module genlock_bit_emit #(
    parameter int SENT_W  = 22,
    parameter int LEAD    = 4,
    parameter int RST_GAP = 7,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [CNT_W-1:0]  slot,
    input  logic [SENT_W-1:0] shadow,
    input  logic              armed,
    input  logic              pin_disable,
    output logic              ser_out,
    output logic              phase_zero
);
    import genlock_pkg::*;

    localparam int DATA_LAST = LEAD + SENT_W;
    localparam int IDX_W     = (SENT_W > 1) ? $clog2(SENT_W) : 1;

    slot_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic             ser_nxt;
    logic             zero_nxt;

    // Next serial level and strobe from the slot kind.
    always_comb begin
        kind     = classify(int'(slot), LEAD, SENT_W, RST_GAP);
        idx      = IDX_W'(DATA_LAST - int'(slot));
        ser_nxt  = 1'b1;
        zero_nxt = 1'b0;
        if (busy) begin
            case (kind)
                SLOT_START: ser_nxt = 1'b0;
                SLOT_DATA:  ser_nxt = shadow[idx];
                SLOT_PHASE: begin
                    ser_nxt  = !armed;
                    zero_nxt = armed;
                end
                default:    ser_nxt = 1'b1;
            endcase
        end
        if (pin_disable) ser_nxt = 1'b1;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out    <= 1'b1;
            phase_zero <= 1'b0;
        end else begin
            ser_out    <= ser_nxt;
            phase_zero <= zero_nxt;
        end
    end

    // R8: the strobe lasts a single cycle.
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_zero |=> !phase_zero);

    // R8: the strobe coincides with a low reset bit unless the pin is disabled.
    assert_strobe_with_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_zero |-> (!ser_out || $past(pin_disable)));

    // R10: a disabled pin stays high.
    assert_disable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_disable |=> ser_out);

endmodule

// File: rtl/genlock_ser_tx.sv
// Top: genlock serial transmitter. Sends a start bit, the upper bits of the
// subcarrier control word MSB first, and a delayed active-low phase-reset
// bit once per scan line, with a strobe for the local phase clear.
// Assumes clk is the serial bit clock and all inputs are synchronous to it.
module genlock_ser_tx #(
    parameter int WORD_W  = 23,
    parameter int LEAD    = 4,
    parameter int RST_GAP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              phase_req,
    input  logic              pin_disable,
    output logic              ser_out,
    output logic              phase_zero
);
    localparam int SENT_W    = WORD_W - 1;
    localparam int RST_SLOT  = LEAD + SENT_W + RST_GAP;
    localparam int FRAME_LEN = RST_SLOT + 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic              busy;
    logic [CNT_W-1:0]  slot;
    logic [SENT_W-1:0] shadow;
    logic              armed;
    logic              pending;

    genlock_frame_timer #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .busy(busy), .slot(slot)
    );

    genlock_word_hold #(.WORD_W(WORD_W), .SENT_W(SENT_W), .CNT_W(CNT_W),
                        .RST_SLOT(RST_SLOT)) u_hold (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .freq_word(freq_word), .phase_req(phase_req), .busy(busy),
        .slot(slot), .shadow(shadow), .armed(armed), .pending(pending)
    );

    genlock_bit_emit #(.SENT_W(SENT_W), .LEAD(LEAD), .RST_GAP(RST_GAP),
                       .CNT_W(CNT_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .busy(busy), .slot(slot),
        .shadow(shadow), .armed(armed), .pin_disable(pin_disable),
        .ser_out(ser_out), .phase_zero(phase_zero)
    );

    // R2: outside a frame the pin returns high.
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> ser_out);

    // R1: reset leaves no request pending.
    assert_reset_clear_R1: assert property (@(posedge clk)
        (!rst_n) |=> (!pending && ser_out && !phase_zero));

endmodule

// File: tb/test_genlock_ser_tx.sv
// Bench: sweeps words and request placements, predicting every slot.
module test_genlock_ser_tx;
    localparam int LEAD      = 4;
    localparam int GAP       = 7;
    localparam int FRAME_LEN = LEAD + 22 + GAP + 1;
    localparam int PH_SLOT   = FRAME_LEN - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [22:0] freq_word = '0;
    logic        phase_req = 1'b0;
    logic        pin_disable = 1'b0;
    logic        ser_out;
    logic        phase_zero;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    genlock_ser_tx #(.WORD_W(23), .LEAD(LEAD), .RST_GAP(GAP)) i_genlock_ser_tx (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .freq_word(freq_word), .phase_req(phase_req),
        .pin_disable(pin_disable), .ser_out(ser_out), .phase_zero(phase_zero)
    );

    task automatic check(input string tag, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_ser(input int k, input logic [22:0] w,
                                     input bit armed, input bit dis);
        if (dis)                 return 1'b1;
        if (k < LEAD)            return 1'b1;
        if (k == LEAD)           return 1'b0;
        if (k <= LEAD + 22)      return w[22 - (k - LEAD - 1)];
        if (k == PH_SLOT)        return armed ? 1'b0 : 1'b1;
        return 1'b1;
    endfunction

    function automatic string slot_tag(input int k);
        if (k <= LEAD)      return "R3";
        if (k <= LEAD + 22) return "R4";
        return "R6";
    endfunction

    // Pulse line_start with a word; ends at the negedge after the sampling edge.
    task automatic start_line(input logic [22:0] w, input bit req_now);
        line_start = 1'b1;
        freq_word  = w;
        phase_req  = req_now;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        phase_req  = 1'b0;
    endtask

    // Check slots of a frame; optional request pulse, word scramble, early stop.
    task automatic watch_frame(input logic [22:0] w, input bit armed,
                               input bit dis, input int stop_at,
                               input int req_at, input int scr_at,
                               input string tag);
        for (int k = 0; k < FRAME_LEN; k++) begin
            if (k == stop_at) return;
            if (k == req_at) phase_req = 1'b1;
            if (k == scr_at) freq_word = ~w;
            @(posedge clk);
            @(negedge clk);
            phase_req = 1'b0;
            check(tag == "" ? slot_tag(k) : tag, ser_out,
                  exp_ser(k, w, armed, dis), $sformatf("ser slot %0d", k));
            check("R8", phase_zero, (armed && k == PH_SLOT) ? 1'b1 : 1'b0,
                  $sformatf("strobe slot %0d", k));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2", ser_out, 1'b1, "idle level");
            check("R2", phase_zero, 1'b0, "idle strobe");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", ser_out, 1'b1, "reset level");
        check("R1", phase_zero, 1'b0, "reset strobe");
        rst_n = 1'b1;
        idle(3);

        // R1/R7: first frame after reset carries no reset bit.
        start_line(23'h5A5A5A, 1'b0);
        watch_frame(23'h5A5A5A, 1'b0, 1'b0, -1, -1, -1, "");
        idle(2);

        // R3/R4: walking ones and walking zeros through all 23 positions.
        for (int b = 0; b < 23; b++) begin
            logic [22:0] w1;
            w1 = 23'd1 << b;
            start_line(w1, 1'b0);
            watch_frame(w1, 1'b0, 1'b0, -1, -1, -1, "");
            idle(1);
            start_line(~w1, 1'b0);
            watch_frame(~w1, 1'b0, 1'b0, -1, -1, -1, "");
            idle(1);
        end

        // R5: word changes mid-frame are ignored.
        start_line(23'h3C0F55, 1'b0);
        watch_frame(23'h3C0F55, 1'b0, 1'b0, -1, -1, LEAD + 2, "R5");
        idle(1);

        // R7: request mid-frame lands on the next frame only.
        start_line(23'h123456, 1'b0);
        watch_frame(23'h123456, 1'b0, 1'b0, -1, 5, -1, "");
        idle(2);
        start_line(23'h654321, 1'b0);
        watch_frame(23'h654321, 1'b1, 1'b0, -1, -1, -1, "R7");
        idle(1);
        start_line(23'h0F0F0F, 1'b0);
        watch_frame(23'h0F0F0F, 1'b0, 1'b0, -1, -1, -1, "R7");
        idle(1);

        // R7: request on the line-start edge counts for that frame.
        start_line(23'h7FFFFF, 1'b1);
        watch_frame(23'h7FFFFF, 1'b1, 1'b0, -1, -1, -1, "R7");
        idle(1);

        // R9: armed frame restarted before its reset slot keeps the reset.
        start_line(23'h2AAAAA, 1'b1);
        watch_frame(23'h2AAAAA, 1'b1, 1'b0, 10, -1, -1, "");
        start_line(23'h155555, 1'b0);
        watch_frame(23'h155555, 1'b1, 1'b0, -1, -1, -1, "R9");
        idle(1);

        // R9: unarmed frame restarted mid-data.
        start_line(23'h000FFF, 1'b0);
        watch_frame(23'h000FFF, 1'b0, 1'b0, 20, -1, -1, "");
        start_line(23'h7FF000, 1'b0);
        watch_frame(23'h7FF000, 1'b0, 1'b0, -1, -1, -1, "R9");
        idle(1);

        // R10: disabled pin stays high; strobe and delivery still happen.
        pin_disable = 1'b1;
        idle(1);
        start_line(23'h0AAAAA, 1'b1);
        watch_frame(23'h0AAAAA, 1'b1, 1'b1, -1, -1, -1, "R10");
        idle(1);
        pin_disable = 1'b0;
        idle(1);
        start_line(23'h0AAAAA, 1'b0);
        watch_frame(23'h0AAAAA, 1'b0, 1'b0, -1, -1, -1, "R10");
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule